// File: doc/BRIEF.md
# Pipelined Carry-Select Add/Subtract/Compare Unit

This block is the adder datapath of a CPU integer ALU. One shared carry-select structure serves addition, addition with an incoming carry, subtraction and comparison. A new operation, with two 64-bit operands, a 2-bit operation code and a carry bit, may be presented on every clock cycle with `inValid` high. The registered sum or difference appears two clock cycles later with `outValid` high. The compare flags appear at the same time, ready for register forwarding or a compare-and-branch decision.

The first pipeline stage captures the operands. During the following cycle the second operand is inverted for subtraction and the word is split into four 16-bit segments. Each segment forms its sum for an incoming carry of 0 and for an incoming carry of 1. A ripple of select carries then picks one sum per segment. The full cycle belongs to this arithmetic, and the second stage registers the result and the flags. A comparison uses the subtract path but marks the result as not to be written back.

Top module: `csel_addsub_unit`

## Requirements
- R1: Operation code 2'b00 (ADD) returns `opA + opB` modulo 2^64 and ignores `inCarry`. `outCarry` is the carry out of bit 63.
- R2: Operation code 2'b01 (SUB) returns `opA - opB` modulo 2^64, computed as `opA + ~opB + 1`, and ignores `inCarry`. `outCarry` is the carry out of that sum, so it is 1 when no borrow occurs.
- R3: Operation code 2'b10 (CMP) computes the same difference and flags as SUB. `outWrite` is 0 for CMP and 1 for every other operation code.
- R4: `outValid` is high in exactly the cycle two clock edges after a cycle with `inValid` high, and low otherwise. A new operation is accepted on every cycle, with no gaps.
- R5: `flagZero` is 1 exactly when the 64-bit result is all zeros.
- R6: `flagUlt` is 1 on SUB and CMP when `opA < opB` as unsigned numbers, which is a carry out of 0. It is 0 for ADD and ADC.
- R7: `flagSlt` is 1 on SUB and CMP when `opA < opB` as two's complement numbers, which is the sign of the difference XOR the signed overflow. It is 0 for ADD and ADC.
- R8: A carry that crosses any 16-bit segment boundary (bits 15/16, 31/32, 47/48) or leaves bit 63 gives the same result as a full-width addition.
- R9: A synchronous active-high `rst` clears `outValid`, `outResult`, `outWrite` and all flags. An operation in flight when reset is applied never produces `outValid`.
- R10: Operation code 2'b11 (ADC) returns `opA + opB + inCarry` modulo 2^64, with `outCarry` the carry out of bit 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation presented this cycle |
| inOp | input | 2 | 00 ADD, 01 SUB, 10 CMP, 11 ADC |
| inCarry | input | 1 | Carry input, used by ADC only |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| outValid | output | 1 | Result and flags valid |
| outWrite | output | 1 | Result is to be written back (0 for CMP) |
| outResult | output | 64 | Sum or difference |
| outCarry | output | 1 | Carry out of bit 63 |
| flagZero | output | 1 | Result is zero |
| flagUlt | output | 1 | Unsigned less-than (SUB/CMP) |
| flagSlt | output | 1 | Signed less-than (SUB/CMP) |

## Verification
The bench sends operands built so that a carry ripples into each 16-bit segment boundary and out of bit 63. A wrong select ripple or a swapped carry-0/carry-1 pick would leave one 16-bit slice off by one. Compares across the sign boundary (0x8000_0000_0000_0000 against 0x7FFF_FFFF_FFFF_FFFF), and equal and all-ones operands, separate the signed flag from the unsigned flag. A design that left out the overflow term, or tested the carry with the wrong polarity, would report the wrong order. `inCarry` is set high on ADD, SUB and CMP to expose leakage of the carry input. A back-to-back stream with a reset dropped into it shows any latency other than two cycles, any lost operation and any in-flight operation that survives the reset.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_ADC = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // load operand registers this cycle
    logic advance;    // stage-1 holds a live op; load result registers
    logic invertB;    // complement second operand
    logic forceOne;   // lowest segment carry-in forced to 1
    logic passCarry;  // lowest segment carry-in taken from captured carry
    logic flagSub;    // compare flags meaningful
  } ctrlStrobe_t;
endpackage

// File: rtl/csel_segment.sv
module csel_segment #(
  parameter int SEG = 16
) (
  input  logic [SEG-1:0] segA,
  input  logic [SEG-1:0] segB,
  output logic [SEG:0]   sumCarry0,
  output logic [SEG:0]   sumCarry1
);
  // both carry hypotheses evaluated in parallel
  assign sumCarry0 = {1'b0, segA} + {1'b0, segB};
  assign sumCarry1 = {1'b0, segA} + {1'b0, segB} + (SEG+1)'(1);
endmodule

// File: rtl/csel_control.sv
module csel_control
  import csel_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  inOp,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        outWrite
);
  logic   s1Valid;
  aluOp_e s1Op;
  logic   s2Valid;
  logic   s2Write;
  logic   s1IsSub;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Op    <= OP_ADD;
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
    end else begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
      if (inValid) s1Op <= aluOp_e'(inOp);
      if (s1Valid) s2Write <= (s1Op != OP_CMP);
    end
  end

  always_comb begin
    s1IsSub          = (s1Op == OP_SUB) || (s1Op == OP_CMP);
    strobe.capture   = inValid;
    strobe.advance   = s1Valid;
    strobe.invertB   = s1IsSub;
    strobe.forceOne  = s1IsSub;
    strobe.passCarry = (s1Op == OP_ADC);
    strobe.flagSub   = s1IsSub;
  end

  assign outValid = s2Valid;
  assign outWrite = s2Write;

  // cycles since reset, saturating, so $past never reaches into reset
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (outValid == $past(inValid, 2)));

  // R3
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inOp == OP_CMP) |=> ##1 (outValid && !outWrite));

  // R3
  write_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inOp != OP_CMP) |=> ##1 (outValid && outWrite));
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int SEG   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             inCarry,
  output logic [WIDTH-1:0] outResult,
  output logic             outCarry,
  output logic             flagZero,
  output logic             flagUlt,
  output logic             flagSlt
);
  localparam int NSEG = WIDTH / SEG;

  logic [WIDTH-1:0] aReg, bReg;
  logic             cReg;
  logic [WIDTH-1:0] bEff;
  logic             cin0;
  logic [NSEG:0]    selCarry;
  logic [WIDTH-1:0] sumWord;
  logic             carryOut;
  logic             ovf;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      aReg <= opA;
      bReg <= opB;
      cReg <= inCarry;
    end
  end

  always_comb begin
    bEff = strobe.invertB ? ~bReg : bReg;
    cin0 = strobe.forceOne | (strobe.passCarry & cReg);
  end

  assign selCarry[0] = cin0;

  for (genvar k = 0; k < NSEG; k++) begin : gSeg
    logic [SEG:0] sum0, sum1;
    csel_segment #(.SEG(SEG)) i_seg (
      .segA      (aReg[k*SEG +: SEG]),
      .segB      (bEff[k*SEG +: SEG]),
      .sumCarry0 (sum0),
      .sumCarry1 (sum1)
    );
    assign selCarry[k+1]          = selCarry[k] ? sum1[SEG] : sum0[SEG];
    assign sumWord[k*SEG +: SEG]  = selCarry[k] ? sum1[SEG-1:0] : sum0[SEG-1:0];
  end

  assign carryOut = selCarry[NSEG];
  assign ovf = (aReg[WIDTH-1] == bEff[WIDTH-1]) && (sumWord[WIDTH-1] != aReg[WIDTH-1]);

  // stage 2: result and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      outResult <= '0;
      outCarry  <= 1'b0;
      flagZero  <= 1'b0;
      flagUlt   <= 1'b0;
      flagSlt   <= 1'b0;
    end else if (strobe.advance) begin
      outResult <= sumWord;
      outCarry  <= carryOut;
      flagZero  <= ~|sumWord;
      flagUlt   <= strobe.flagSub & ~carryOut;
      flagSlt   <= strobe.flagSub & (sumWord[WIDTH-1] ^ ovf);
    end
  end

  // R8: each segment's select carry matches a full-width add of the bits below it
  for (genvar k = 1; k < NSEG; k++) begin : gBoundary
    localparam int LO = k * SEG;
    logic [LO:0] refLow;
    assign refLow = {1'b0, aReg[LO-1:0]} + {1'b0, bEff[LO-1:0]} + (LO+1)'(cin0);
    // R8
    seg_carry_chk: assert property (@(posedge clk) disable iff (rst)
      strobe.advance |-> ((refLow >> LO) == (LO+1)'(selCarry[k])));
  end

  // R1
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> (outResult == $past(aReg + bEff + WIDTH'(cin0))));

  // R6
  ult_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && strobe.flagSub) |=> (flagUlt == $past(aReg < bReg)));

  // R7
  slt_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && strobe.flagSub) |=> (flagSlt == $past($signed(aReg) < $signed(bReg))));

  // R5
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && strobe.flagSub) |=> (flagZero == $past(aReg == bReg)));
endmodule

// File: rtl/csel_addsub_unit.sv
module csel_addsub_unit
  import csel_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int SEG   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       inOp,
  input  logic             inCarry,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             outValid,
  output logic             outWrite,
  output logic [WIDTH-1:0] outResult,
  output logic             outCarry,
  output logic             flagZero,
  output logic             flagUlt,
  output logic             flagSlt
);
  ctrlStrobe_t strobe;

  csel_control i_control (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inOp     (inOp),
    .strobe   (strobe),
    .outValid (outValid),
    .outWrite (outWrite)
  );

  csel_datapath #(.WIDTH(WIDTH), .SEG(SEG)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .inCarry   (inCarry),
    .outResult (outResult),
    .outCarry  (outCarry),
    .flagZero  (flagZero),
    .flagUlt   (flagUlt),
    .flagSlt   (flagSlt)
  );
endmodule

// File: tb/test_csel_addsub_unit.sv
module test_csel_addsub_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'b00;
  logic        inCarry = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid, outWrite, outCarry, flagZero, flagUlt, flagSlt;
  logic [63:0] outResult;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  csel_addsub_unit i_csel_addsub_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp), .inCarry(inCarry),
    .opA(opA), .opB(opB), .outValid(outValid), .outWrite(outWrite),
    .outResult(outResult), .outCarry(outCarry), .flagZero(flagZero),
    .flagUlt(flagUlt), .flagSlt(flagSlt)
  );

  // queued operations
  logic [63:0] qa [16];
  logic [63:0] qb [16];
  logic [1:0]  qop[16];
  logic        qc [16];
  int          qn = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [63:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b, input logic c);
    qa[qn] = a; qb[qn] = b; qop[qn] = op; qc[qn] = c;
    qn++;
  endtask

  task automatic checkEntry(input int i, input string tag);
    logic [64:0] full;
    logic        sub;
    sub = (qop[i] == 2'b01) || (qop[i] == 2'b10);
    case (qop[i])
      2'b00:   full = {1'b0, qa[i]} + {1'b0, qb[i]};
      2'b11:   full = {1'b0, qa[i]} + {1'b0, qb[i]} + {64'd0, qc[i]};
      default: full = {1'b0, qa[i]} + {1'b0, ~qb[i]} + 65'd1;
    endcase
    chk(tag, "valid",  {63'd0, outValid}, 64'd1);
    chk(tag, "result", outResult, full[63:0]);
    chk(tag, "carry",  {63'd0, outCarry}, {63'd0, full[64]});
    chk(tag, "write",  {63'd0, outWrite}, {63'd0, qop[i] != 2'b10});
    chk(tag, "zero",   {63'd0, flagZero}, {63'd0, full[63:0] == 64'd0});
    chk(tag, "ult",    {63'd0, flagUlt},  {63'd0, sub && (qa[i] < qb[i])});
    chk(tag, "slt",    {63'd0, flagSlt},  {63'd0, sub && ($signed(qa[i]) < $signed(qb[i]))});
  endtask

  // drive one op per cycle, check each two edges later
  task automatic runStream(input string tag);
    for (int i = 0; i < qn + 2; i++) begin
      @(negedge clk);
      if (i >= 2) checkEntry(i - 2, tag);
      if (i < qn) begin
        inValid = 1'b1; inOp = qop[i]; opA = qa[i]; opB = qb[i]; inCarry = qc[i];
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk(tag, "valid after stream", {63'd0, outValid}, 64'd0);
    qn = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R9", "reset valid",  {63'd0, outValid}, 64'd0);
    chk("R9", "reset result", outResult, 64'd0);
    chk("R9", "reset flags",  {61'd0, flagZero, flagUlt, flagSlt}, 64'd0);
  endtask

  task automatic testAdd();
    push(2'b00, 64'd5, 64'd7, 1'b0);
    push(2'b00, 64'd5, 64'd7, 1'b1);  // inCarry ignored
    push(2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1);
    runStream("R1");
  endtask

  task automatic testAdc();
    push(2'b11, 64'd5, 64'd7, 1'b1);
    push(2'b11, 64'd5, 64'd7, 1'b0);
    push(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
    runStream("R10");
  endtask

  task automatic testSub();
    push(2'b01, 64'd100, 64'd1, 1'b0);
    push(2'b01, 64'd100, 64'd1, 1'b1);  // inCarry ignored
    push(2'b01, 64'd1, 64'd2, 1'b1);
    push(2'b01, 64'h8000_0000_0000_0000, 64'd1, 1'b0);
    runStream("R2");
  endtask

  task automatic testCmp();
    push(2'b10, 64'd3, 64'd9, 1'b1);
    push(2'b10, 64'd9, 64'd3, 1'b0);
    push(2'b10, 64'd42, 64'd42, 1'b0);
    runStream("R3");
  endtask

  task automatic testBoundaries();
    push(2'b00, 64'h0000_0000_0000_FFFF, 64'd1, 1'b0);
    push(2'b00, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0);
    push(2'b00, 64'h0000_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    push(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    push(2'b01, 64'h0000_0001_0000_0000, 64'd1, 1'b0);
    push(2'b01, 64'd0, 64'd1, 1'b0);
    push(2'b00, 64'hFFFF_0000_FFFF_0000, 64'h0001_0000_0001_0000, 1'b0);
    runStream("R8");
  endtask

  task automatic testFlags();
    push(2'b10, 64'd0, 64'd0, 1'b0);
    push(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    push(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);   // ADD zero, ult/slt stay 0
    runStream("R5");
    push(2'b10, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    push(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    push(2'b00, 64'd1, 64'd2, 1'b0);
    runStream("R6");
    push(2'b10, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
    push(2'b10, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0);
    push(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
    push(2'b10, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    runStream("R7");
  endtask

  task automatic testStream();
    for (int i = 0; i < 12; i++) begin
      logic [63:0] a, b;
      a = nextRand();
      b = nextRand();
      push(2'(i), a, b, a[3]);
    end
    runStream("R4");
  endtask

  task automatic testResetFlush();
    @(negedge clk);
    inValid = 1'b1; inOp = 2'b00; opA = 64'd11; opB = 64'd22; inCarry = 1'b0;
    @(negedge clk);
    inValid = 1'b1; opA = 64'd33;
    rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9", "valid during reset", {63'd0, outValid}, 64'd0);
    chk("R9", "result during reset", outResult, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "flushed valid 1", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    chk("R9", "flushed valid 2", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testAdd();
    testAdc();
    testSub();
    testCmp();
    testBoundaries();
    testFlags();
    testStream();
    testResetFlush();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule